// File: doc/BRIEF.md
# Edge-Triggered Bit Shift Register

This block keeps a short row of single bits and moves the whole row one place toward its least significant end each time a level-sensitive advance input goes from low to high. As the row moves, the bit that was in position 0 is kept in a separate unload flag. A serial data bit is written into the vacated most significant position. The advance input is an ordinary level, such as a sensor or a debounced control line. The block detects its rising edges itself, so holding the line high produces one shift and no more.

The block is used as a bit-level delay line that counts events. A bit that enters at the top reaches the unload flag after as many further advance edges as the register is wide. Between shifts, the unload flag keeps the last bit that left the register, so the flag can be read at any time.

Top module: `bit_shift_reg`

## Requirements
- R1: While `rst` is high at a clock edge, `bits` and `unload` become 0 at that edge, and the edge detector's history becomes low. As a result, if `advance` is high in the first cycle after reset, that cycle counts as a rising edge.
- R2: When a rising edge of `advance` is seen at a clock edge, `unload` takes the value that `bits[0]` had before that edge. The new value is visible right after that same clock edge.
- R3: On a shift, each position `bits[i]` for i from 0 to WIDTH-2 takes the old `bits[i+1]`. `bits[WIDTH-1]` takes the value of `ser_in` sampled at that clock edge.
- R4: When `advance` is low, or has been high since the previous clock edge, `bits` and `unload` do not change. Holding `advance` high for many cycles gives exactly one shift.
- R5: `unload` keeps its value for any number of cycles between shifts.
- R6: With the default WIDTH of 5, a bit written into `bits[4]` appears on `unload` after exactly 5 further rising edges of `advance`.
- R7: `advance` is sampled once per clock. A rising edge is a sample of 1 whose previous sample was 0. A high level lasting a single clock cycle counts as one edge, and so does each high in an alternating 1,0,1,0 pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Level input; each rising transition requests one shift |
| ser_in | input | 1 | Serial bit written into the most significant position on a shift |
| bits | output | WIDTH | Current register contents |
| unload | output | 1 | Last bit shifted out of position 0 |

## Verification
On every cycle, the assertions check three things: the reset values, the exact effect of a detected edge on the row and on the unload flag, and that nothing moves when no edge is detected. The edge they watch for is seen by an observer that samples `advance` independently of the design. Other behaviour needs the bench's scenarios. These are the five-edge transit of a marked bit to the unload flag, the single shift produced by a level held high for many cycles, and alternating single-cycle pulses. The bench also checks that a level already high when reset ends produces a shift in the first cycle after reset.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    // Default row length of the shift register
    localparam int BSR_DEFAULT_WIDTH = 5;

    // State kept by the advance edge detector
    typedef struct packed {
        logic prev;
    } bsr_edge_state_t;
endpackage

// File: rtl/bsr_edge_det.sv
module bsr_edge_det
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    bsr_edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise_o    = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/bsr_shift_core.sv
module bsr_shift_core #(
    parameter int WIDTH = bsr_pkg::BSR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] bits_o,
    output logic             unload_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] row;
        logic             out_bit;
    } core_state_t;

    core_state_t      st_d, st_q;
    logic [WIDTH-1:0] moved;

    // Each lower position takes its upper neighbour; the top takes the serial bit
    for (genvar g = 0; g < MSB; g++) begin : g_move
        assign moved[g] = st_q.row[g+1];
    end
    assign moved[MSB] = ser_i;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.out_bit = st_q.row[0];
            st_d.row     = moved;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bits_o   = st_q.row;
    assign unload_o = st_q.out_bit;
endmodule

// File: rtl/bit_shift_reg.sv
module bit_shift_reg #(
    parameter int WIDTH = bsr_pkg::BSR_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits,
    output logic             unload
);
    logic step;

    bsr_edge_det i_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (advance),
        .rise_o  (step)
    );

    bsr_shift_core #(.WIDTH(WIDTH)) i_core (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .ser_i    (ser_in),
        .bits_o   (bits),
        .unload_o (unload)
    );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int WIDTH = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             advance,
    input logic             ser_in,
    input logic [WIDTH-1:0] bits,
    input logic             unload
);
    // Independent observer of the advance level
    logic obs_prev;
    always_ff @(posedge clk) begin
        if (rst) obs_prev <= 1'b0;
        else     obs_prev <= advance;
    end

    logic edge_seen;
    assign edge_seen = advance & ~obs_prev;

    initial begin
        AST_WIDTH_MIN: assert (WIDTH >= 2); // R3
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (bits == '0) && (unload == 1'b0)); // R1

    AST_UNLOAD_TAKES_LSB: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> unload == $past(bits[0])); // R2

    AST_ROW_MOVES_DOWN: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> bits == {$past(ser_in), $past(bits[WIDTH-1:1])}); // R3

    AST_NO_EDGE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !edge_seen |=> $stable(bits)); // R4

    AST_UNLOAD_HELD: assert property (@(posedge clk) disable iff (rst)
        !edge_seen |=> $stable(unload)); // R5
endmodule

bind bit_shift_reg bsr_checker #(.WIDTH(WIDTH)) i_bsr_checker (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .ser_in  (ser_in),
    .bits    (bits),
    .unload  (unload)
);

// File: tb/test_bit_shift_reg.sv
module test_bit_shift_reg;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         advance = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] bits;
    logic         unload;

    always #4 clk = ~clk;  // 125 MHz

    bit_shift_reg #(.WIDTH(W)) i_bit_shift_reg (
        .clk(clk), .rst(rst), .advance(advance), .ser_in(ser_in),
        .bits(bits), .unload(unload)
    );

    typedef struct {
        logic [W-1:0] bits;
        logic         unl;
        string        tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model built from the requirements
    logic [W-1:0] m_bits = '0;
    logic         m_unl  = 1'b0;
    logic         m_prev = 1'b0;

    task automatic step(input logic r, input logic a, input logic s, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; advance = a; ser_in = s;
        if (r) begin
            m_bits = '0; m_unl = 1'b0; m_prev = 1'b0;
        end else begin
            if (a && !m_prev) begin
                m_unl  = m_bits[0];
                m_bits = {s, m_bits[W-1:1]};
            end
            m_prev = a;
        end
        @(posedge clk);
        #1;
        e.bits = m_bits; e.unl = m_unl; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares outputs one half period after each edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (bits !== e.bits || unload !== e.unl) begin
                    fails++;
                    $display("FAIL %s: bits=%b unload=%b expected bits=%b unload=%b",
                             e.tag, bits, unload, e.bits, e.unl);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [W-1:0] pat;
        // R1: reset with advance held high; first cycle after reset is an edge
        step(1, 1, 1, "R1");
        step(1, 1, 1, "R1");
        step(0, 1, 1, "R1");
        step(0, 1, 0, "R4");
        step(0, 0, 0, "R4");
        // R2 R3: load a pattern with pulses separated by low cycles
        pat = 5'b10110;
        for (int i = 0; i < W; i++) begin
            step(0, 1, pat[i], "R3");
            step(0, 0, 1'b0, "R2");
        end
        // R4: hold high for many cycles, data changing
        step(0, 1, 1, "R2");
        for (int i = 0; i < 6; i++) step(0, 1, i[0], "R4");
        // R5: long idle with advance low
        for (int i = 0; i < 8; i++) step(0, 0, ~i[0], "R5");
        // R6: clear with zeros, mark one bit, then 5 further edges
        for (int i = 0; i < W; i++) begin
            step(0, 1, 0, "R6");
            step(0, 0, 0, "R6");
        end
        step(0, 1, 1, "R6");
        step(0, 0, 0, "R6");
        for (int i = 0; i < W; i++) begin
            step(0, 1, 0, "R6");
            step(0, 0, 0, "R6");
            step(0, 0, 0, "R5");
        end
        // R7: alternating single-cycle pulses
        for (int i = 0; i < 12; i++) step(0, ~i[0], i[1], "R7");
        // R1: reset in mid-run
        step(0, 1, 1, "R7");
        step(1, 0, 0, "R1");
        step(0, 0, 1, "R1");
        step(0, 1, 1, "R1");
        step(0, 0, 0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule